// File: doc/BRIEF.md
# Stacked LED Scan-Line Sequencer

This block picks which line switch a single LED matrix driver turns on. Up to four of these drivers can be chained to scan one matrix, and each driver owns 16 line switches. Every device in the chain sees the same line-advance pulse, so each keeps an identical global line counter. From that count the device works out three things: which device in the chain owns the line, which of its own switches the line lands on, and whether that switch is enabled.

The visiting order of the devices comes from a 3-bit stacking code. Some codes use a non-sequential order, so a later device can be scanned before an earlier one. A per-device reverse bit flips the switch numbering, so a device mounted upside down still scans from top to bottom. An active-line count shortens the frame, and the counter wraps before it reaches the unused lines at the tail of the last segment.

The configuration is captured only at frame start or reset. That way, a host can change settings mid-frame without tearing the scan.

Top module: `stacked_scan_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cur_line` = 0, `ls_en` = 0 and `own_line` = 0.
- R2: The first `line_adv` pulse after reset or after a frame start selects global line 0, which belongs to the first device in the mode's order.
- R3: Each later `line_adv` pulse adds one to `cur_line`. The pulse that follows the last active line returns `cur_line` to 0.
- R4: A `frame_start` pulse sets `cur_line` to 0 and clears `ls_en` until the next advance. It takes priority over a `line_adv` pulse in the same cycle.
- R5: The number of lines in a frame depends on the mode code. Code 0 gives 16 lines, code 1 gives 32, codes 2 to 5 give 48, and codes 6 and 7 give 64. Codes 0 and 1 use 2 devices, codes 2 to 5 use 3, and codes 6 and 7 use 4.
- R6: Segment s covers global lines 16·s to 16·s+15, and the mode code decides which device owns it. `dev_pos` 0 to 3 name devices 1 to 4. Code 1 visits positions 0,1. Codes 2 and 4 visit 0,1,2. Codes 3 and 5 visit 0,2,1. Code 6 visits 0,1,2,3. Code 7 visits 0,3,1,2.
- R7: In mode code 0, positions 0 and 1 each own every line 0 to 15 at the same time.
- R8: The local index is k = line mod 16. With `scan_rev` = 0 the owning device enables switch k, which is bit k of `ls_en`. With `scan_rev` = 1 it enables switch 15−k.
- R9: The active-line count is limited to the mode's total. A count of 0, or a count larger than the total, means the full total. A smaller count ends the frame early, and the lines that are skipped are the last ones of the final segment in the visiting order.
- R10: Mode, position, reverse bit and active-line count are sampled only in a cycle with `rst` or `frame_start`. Changes at other times have no effect until the next frame start.
- R11: A device whose position is equal to or larger than the mode's device count keeps `ls_en` at 0.
- R12: `ls_en` never has more than one bit set. `own_line` is 1 exactly when `ls_en` is non-zero.
- R13: `cur_line` shows the global line number of the current scan step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also samples the configuration |
| frame_start | input | 1 | Restarts the frame and samples the configuration |
| line_adv | input | 1 | Shared line-advance pulse |
| mode_code | input | 3 | Stacking mode code |
| dev_pos | input | 2 | This device's position in the chain (0 = first) |
| scan_rev | input | 1 | Reverses this device's switch numbering |
| active_lines | input | 7 | Number of active lines; 0 means the full mode total |
| ls_en | output | 16 | One-hot line-switch enables |
| cur_line | output | 6 | Current global line number |
| own_line | output | 1 | This device owns the current line |

## Verification
The bench sweeps every combination of mode code, position and reverse bit. It runs each one with a full count, a count two short of the total, a short count and a count of zero, and every advance in each frame is compared with an order table written independently in the bench.

Several specific mistakes would show up:
- A design that treats codes 3, 5 or 7 as sequential would light the wrong device in the second segment.
- A design that forgets the reversed mapping would light switch k in place of switch 15−k.
- A design that wraps at the mode total instead of the clamped count would light the skipped tail switches.

Separate tests cover the following cases:
- A mid-frame change of the mode and position. A design that samples the configuration continuously would drop or move the lit switch.
- A frame start that arrives together with an advance. A design that gives the advance priority would show line 0 lit at once.
- A position beyond the device count, which must stay dark in every mode.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_SPLIT16  = 3'd0,
    MODE_CHAIN32  = 3'd1,
    MODE_T48_SEQ  = 3'd2,
    MODE_T48_SWAP = 3'd3,
    MODE_W48_SEQ  = 3'd4,
    MODE_W48_SWAP = 3'd5,
    MODE_Q64_SEQ  = 3'd6,
    MODE_Q64_INTL = 3'd7
  } stack_mode_e;

  // number of devices taking part in a mode
  function automatic int mode_devs(input logic [MODE_W-1:0] m);
    case (m)
      MODE_SPLIT16, MODE_CHAIN32: return 2;
      MODE_Q64_SEQ, MODE_Q64_INTL: return 4;
      default: return 3;
    endcase
  endfunction

  // lines in one full frame of a mode
  function automatic int mode_span(input logic [MODE_W-1:0] m, input int seg);
    if (m == MODE_SPLIT16) return seg;
    return mode_devs(m) * seg;
  endfunction

  // device position that owns segment slot in a mode
  function automatic int slot_dev(input logic [MODE_W-1:0] m, input int slot);
    case (m)
      MODE_T48_SWAP, MODE_W48_SWAP: begin
        case (slot)
          1: return 2;
          2: return 1;
          default: return slot;
        endcase
      end
      MODE_Q64_INTL: begin
        case (slot)
          1: return 3;
          2: return 1;
          3: return 2;
          default: return slot;
        endcase
      end
      default: return slot;
    endcase
  endfunction

endpackage

// File: rtl/scan_cfg_latch.sv
module scan_cfg_latch #(
  parameter int MODE_W = 3,
  parameter int POS_W  = 2,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             load,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [POS_W-1:0]  pos_in,
  input  logic             rev_in,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic [MODE_W-1:0] mode_q,
  output logic [POS_W-1:0]  pos_q,
  output logic             rev_q,
  output logic [CNT_W-1:0]  cnt_q
);

  always_ff @(posedge clk) begin
    if (load) begin
      mode_q <= mode_in;
      pos_q  <= pos_in;
      rev_q  <= rev_in;
      cnt_q  <= cnt_in;
    end
  end

endmodule

// File: rtl/scan_line_counter.sv
module scan_line_counter #(
  parameter int LINE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             adv,
  input  logic [LINE_W-1:0] last_line,
  output logic [LINE_W-1:0] line,
  output logic             live
);

  logic at_last;
  assign at_last = (line == last_line);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      line <= '0;
      live <= 1'b0;
    end else if (adv) begin
      if (!live) begin
        live <= 1'b1;
        line <= '0;
      end else if (at_last) begin
        line <= '0;
      end else begin
        line <= line + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_seg_decode.sv
module scan_seg_decode
  import scan_seq_pkg::*;
#(
  parameter int SEG_LINES = 16,
  parameter int POS_W     = 2,
  parameter int LINE_W    = 6
) (
  input  logic [LINE_W-1:0]    line,
  input  logic                 live,
  input  logic [MODE_W-1:0]    mode,
  input  logic [POS_W-1:0]     pos,
  input  logic                 rev,
  output logic [SEG_LINES-1:0] en,
  output logic                 own
);

  localparam int IDX_W = $clog2(SEG_LINES);

  logic [IDX_W-1:0] local_idx;
  logic [IDX_W-1:0] sw_idx;
  logic             owner;
  int               seg_slot;

  always_comb begin
    seg_slot  = int'(line) / SEG_LINES;
    local_idx = IDX_W'(int'(line) % SEG_LINES);
    sw_idx    = rev ? (IDX_W'(SEG_LINES - 1) - local_idx) : local_idx;
    if (mode == MODE_SPLIT16)
      owner = (int'(pos) < mode_devs(mode));
    else
      owner = (slot_dev(mode, seg_slot) == int'(pos));
  end

  assign own = live && owner;

  for (genvar gi = 0; gi < SEG_LINES; gi++) begin : g_sw
    assign en[gi] = own && (sw_idx == IDX_W'(gi));
  end

endmodule

// File: rtl/stacked_scan_seq.sv
module stacked_scan_seq
  import scan_seq_pkg::*;
#(
  parameter int SEG_LINES = 16,
  parameter int MAX_DEVS  = 4,
  parameter int POS_W     = $clog2(MAX_DEVS),
  parameter int LINE_W    = $clog2(SEG_LINES * MAX_DEVS),
  parameter int CNT_W     = LINE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 line_adv,
  input  logic [MODE_W-1:0]    mode_code,
  input  logic [POS_W-1:0]     dev_pos,
  input  logic                 scan_rev,
  input  logic [CNT_W-1:0]     active_lines,
  output logic [SEG_LINES-1:0] ls_en,
  output logic [LINE_W-1:0]    cur_line,
  output logic                 own_line
);

  logic [MODE_W-1:0] cfg_mode;
  logic [POS_W-1:0]  cfg_pos;
  logic              cfg_rev;
  logic [CNT_W-1:0]  cfg_cnt;
  logic [LINE_W-1:0] frame_last;
  logic [POS_W:0]    cfg_devs;
  logic              scan_live;
  logic              cfg_load;

  assign cfg_load = rst || frame_start;

  scan_cfg_latch #(
    .MODE_W(MODE_W), .POS_W(POS_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .load(cfg_load),
    .mode_in(mode_code), .pos_in(dev_pos), .rev_in(scan_rev), .cnt_in(active_lines),
    .mode_q(cfg_mode), .pos_q(cfg_pos), .rev_q(cfg_rev), .cnt_q(cfg_cnt)
  );

  always_comb begin
    int span;
    int lim;
    span = mode_span(cfg_mode, SEG_LINES);
    if (cfg_cnt == '0 || int'(cfg_cnt) > span) lim = span;
    else lim = int'(cfg_cnt);
    frame_last = LINE_W'(lim - 1);
    cfg_devs   = (POS_W + 1)'(mode_devs(cfg_mode));
  end

  scan_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(frame_start), .adv(line_adv),
    .last_line(frame_last), .line(cur_line), .live(scan_live)
  );

  scan_seg_decode #(
    .SEG_LINES(SEG_LINES), .POS_W(POS_W), .LINE_W(LINE_W)
  ) u_dec (
    .line(cur_line), .live(scan_live), .mode(cfg_mode), .pos(cfg_pos),
    .rev(cfg_rev), .en(ls_en), .own(own_line)
  );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int SEG_LINES = 16,
  parameter int POS_W     = 2,
  parameter int LINE_W    = 6,
  parameter int MODE_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_start,
  input logic                 line_adv,
  input logic [SEG_LINES-1:0] ls_en,
  input logic [LINE_W-1:0]    cur_line,
  input logic                 own_line,
  input logic [LINE_W-1:0]    frame_last,
  input logic [MODE_W-1:0]    cfg_mode,
  input logic [POS_W-1:0]     cfg_pos,
  input logic [POS_W:0]       cfg_devs,
  input logic                 scan_live
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cur_line == '0 && ls_en == '0 && !own_line));

  // R12
  one_switch_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ls_en));

  // R12
  own_match_chk: assert property (@(posedge clk) disable iff (rst)
    own_line == (ls_en != '0));

  // R3
  line_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cur_line <= frame_last);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_live && line_adv && !frame_start && cur_line == frame_last) |=> cur_line == '0);

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cur_line == '0 && ls_en == '0));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(cfg_mode) && $stable(cfg_pos)));

  // R11
  idle_dev_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cfg_pos} >= cfg_devs) |-> ls_en == '0);

endmodule

bind stacked_scan_seq scan_seq_chk #(
  .SEG_LINES(SEG_LINES), .POS_W(POS_W), .LINE_W(LINE_W), .MODE_W(scan_seq_pkg::MODE_W)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .line_adv(line_adv),
  .ls_en(ls_en), .cur_line(cur_line), .own_line(own_line),
  .frame_last(frame_last), .cfg_mode(cfg_mode), .cfg_pos(cfg_pos),
  .cfg_devs(cfg_devs), .scan_live(scan_live)
);

// File: tb/stacked_scan_seq_test.sv
module stacked_scan_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        line_adv = 1'b0;
  logic [2:0]  mode_code = 3'd1;
  logic [1:0]  dev_pos = 2'd0;
  logic        scan_rev = 1'b0;
  logic [6:0]  active_lines = 7'd0;
  logic [15:0] ls_en;
  logic [5:0]  cur_line;
  logic        own_line;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  stacked_scan_seq uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_adv(line_adv),
    .mode_code(mode_code), .dev_pos(dev_pos), .scan_rev(scan_rev),
    .active_lines(active_lines), .ls_en(ls_en), .cur_line(cur_line), .own_line(own_line)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int span_of(input int m);
    if (m == 0) return 16;
    if (m == 1) return 32;
    if (m < 6) return 48;
    return 64;
  endfunction

  function automatic int devs_of(input int m);
    if (m < 2) return 2;
    if (m < 6) return 3;
    return 4;
  endfunction

  function automatic int dev_at(input int m, input int slot);
    if (m == 3 || m == 5) return (slot == 0) ? 0 : 3 - slot;
    if (m == 7) return (slot == 0) ? 0 : ((slot == 1) ? 3 : slot - 1);
    return slot;
  endfunction

  function automatic int exp_en(input int m, input int p, input int r, input int ln, input bit live);
    bit mine;
    int k;
    if (!live) return 0;
    if (m == 0) mine = (p < 2);
    else mine = (dev_at(m, ln / 16) == p);
    if (!mine) return 0;
    k = ln % 16;
    if (r != 0) k = 15 - k;
    return 1 << k;
  endfunction

  task automatic advance();
    line_adv = 1'b1;
    @(negedge clk);
    line_adv = 1'b0;
  endtask

  task automatic start_frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic run_cfg(input int m, input int p, input int r, input int al);
    int lim;
    int eline;
    bit live;
    int e;
    string tag;
    lim = (al == 0 || al > span_of(m)) ? span_of(m) : al;
    mode_code = 3'(m);
    dev_pos = 2'(p);
    scan_rev = r[0];
    active_lines = 7'(al);
    start_frame();
    chk("R4 line after frame start", int'(cur_line), 0);
    chk("R4 enables after frame start", int'(ls_en), 0);
    eline = 0;
    live = 1'b0;
    for (int s = 0; s < lim + 2; s++) begin
      if (!live) begin
        live = 1'b1;
        eline = 0;
      end else begin
        eline = (eline + 1 == lim) ? 0 : eline + 1;
      end
      advance();
      e = exp_en(m, p, r, eline, live);
      if (s == 0) tag = "R2 first line";
      else if (p >= devs_of(m)) tag = "R11 idle position";
      else if (m == 0) tag = "R7 parallel split";
      else tag = "R6 order R8 mapping";
      chk(tag, int'(ls_en), e);
      chk("R13 R3 R5 R9 line count", int'(cur_line), eline);
      chk("R12 owner flag", int'(own_line), (e != 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 line", int'(cur_line), 0);
    chk("R1 enables", int'(ls_en), 0);
    chk("R1 owner", int'(own_line), 0);
    rst = 1'b0;
    @(negedge clk);
    advance();
    chk("R2 first line after reset", int'(ls_en), 16'h0001);

    // R10: mid-frame config change is ignored
    mode_code = 3'd1; dev_pos = 2'd1; scan_rev = 1'b1; active_lines = 7'd0;
    start_frame();
    for (int i = 0; i < 17; i++) advance();
    chk("R10 before change", int'(ls_en), 16'h8000);
    mode_code = 3'd7; dev_pos = 2'd1; scan_rev = 1'b0; active_lines = 7'd20;
    advance();
    chk("R10 after change enables", int'(ls_en), 16'h4000);
    chk("R10 after change line", int'(cur_line), 17);
    for (int i = 0; i < 5; i++) advance();
    chk("R10 count held", int'(cur_line), 22);

    // R4: frame start wins over a simultaneous advance
    frame_start = 1'b1;
    line_adv = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    line_adv = 1'b0;
    chk("R4 collide line", int'(cur_line), 0);
    chk("R4 collide enables", int'(ls_en), 0);

    // R1 reset mid-run
    mode_code = 3'd6; dev_pos = 2'd0; scan_rev = 1'b0; active_lines = 7'd0;
    start_frame();
    for (int i = 0; i < 4; i++) advance();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run line", int'(cur_line), 0);
    chk("R1 mid-run enables", int'(ls_en), 0);

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 2; r++) begin
          run_cfg(m, p, r, 0);
          run_cfg(m, p, r, span_of(m) - 2);
          run_cfg(m, p, r, 5);
          run_cfg(m, p, r, 100);
        end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule